// File: doc/BRIEF.md
# Free-Running Timer with Coherent Split Read

This block is a 12-bit up-counter that advances on a one-cycle tick enable, nominally a 1 MHz tick, and runs without pause from reset. Because the count is 12 bits, it can time intervals of up to about 4 ms. Software reads the count over an 8-bit bus as two bytes.

A read of the low byte returns the live counter bits 7:0. The same read copies bits 11:8 into a holding nibble. A later read of the high byte returns that held nibble and not the live upper bits. The two bytes therefore always describe one instant of the count, however many ticks pass between the two reads.

Two periodic interrupt requests come from falling edges of internal counter bits. One fires every 128 ticks and the other every 1024 ticks. Each request is a single-cycle pulse, and interrupt controllers elsewhere on the chip consume them.

Top module: `ftmr_top`

## Requirements
- R1: A synchronous active-high reset clears the counter, the holding nibble, `rdata`, `irq_fast` and `irq_slow` to zero.
- R2: The counter increments by one at each clock edge where `tick` is high and holds its value at every other edge.
- R3: The counter wraps from 0xFFF to 0x000 on the next tick.
- R4: A read (`rd_en` high) at address 0x24 loads `rdata` at that clock edge with counter bits 7:0 as they were before any increment at the same edge; `rdata` is therefore valid in the cycle after the strobe.
- R5: A read at address 0x24 copies counter bits 11:8, sampled at that same edge, into the holding nibble.
- R6: A read at address 0x25 returns the holding nibble in `rdata` bits 3:0 and zero in bits 7:4, whatever the live counter bits 11:8 are.
- R7: `irq_fast` is high for exactly one cycle, the cycle after the tick that moves counter bit 6 from 1 to 0, which happens once every 128 ticks.
- R8: `irq_slow` is high for exactly one cycle, the cycle after the tick that moves counter bit 9 from 1 to 0, which happens once every 1024 ticks; it coincides with an `irq_fast` pulse.
- R9: A read at any other address sets `rdata` to 0x00 and leaves the holding nibble unchanged.
- R10: When `rd_en` is low, `rdata` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle count enable (nominally 1 MHz) |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Register address (0x24 low byte, 0x25 high byte) |
| rdata | output | 8 | Registered read data |
| irq_fast | output | 1 | Pulse every 128 ticks |
| irq_slow | output | 1 | Pulse every 1024 ticks |

## Verification
The bench separates the low and high reads by hundreds of ticks that carry the upper nibble forward. A design that returned live upper bits would then report a value that is too large. It reads the low byte in the same cycle as a tick and expects the value from before the increment. A design that read the incremented value would be off by one. It counts interrupt pulses across a full wrap and checks their exact cycle and width: a level-sensitive or rising-edge detector would give wrong counts or stretched pulses. It also confirms that an unmapped read does not disturb the held nibble and that reset clears it.

// File: rtl/ftmr_pkg.sv
package ftmr_pkg;
  localparam int CNT_W     = 12;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int FAST_TAP  = 6;
  localparam int SLOW_TAP  = 9;
  localparam int NUM_IRQ   = 2;
  localparam logic [ADDR_W-1:0] LO_ADDR = 8'h24;
  localparam logic [ADDR_W-1:0] HI_ADDR = 8'h25;

  // counter bit whose falling edge drives interrupt request i
  function automatic int irq_tap(input int i);
    return (i == 0) ? FAST_TAP : SLOW_TAP;
  endfunction
endpackage

// File: rtl/ftmr_count.sv
module ftmr_count #(
  parameter int CNT_W = ftmr_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst)       count_q <= '0;
    else if (tick) count_q <= count_q + 1'b1;  // natural wrap at all-ones
  end

  assign count_o = count_q;
endmodule

// File: rtl/ftmr_irq_tap.sv
module ftmr_irq_tap #(
  parameter int TAP = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [TAP:0] low_bits,
  output logic         irq_o
);
  logic irq_q;

  // bit TAP falls exactly when the bits up to TAP are all ones and a tick arrives
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= tick && (&low_bits);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/ftmr_rdport.sv
module ftmr_rdport #(
  parameter int                CNT_W   = ftmr_pkg::CNT_W,
  parameter int                DATA_W  = ftmr_pkg::DATA_W,
  parameter int                ADDR_W  = ftmr_pkg::ADDR_W,
  parameter logic [ADDR_W-1:0] LO_ADDR = ftmr_pkg::LO_ADDR,
  parameter logic [ADDR_W-1:0] HI_ADDR = ftmr_pkg::HI_ADDR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-DATA_W-1:0] shadow_o
);
  localparam int HI_W  = CNT_W - DATA_W;
  localparam int PAD_W = DATA_W - HI_W;

  logic [HI_W-1:0]   shadow_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      rdata_q  <= '0;
    end else if (rd_en) begin
      if (addr == LO_ADDR) begin
        rdata_q  <= count[DATA_W-1:0];
        shadow_q <= count[CNT_W-1:DATA_W];
      end else if (addr == HI_ADDR) begin
        rdata_q  <= {{PAD_W{1'b0}}, shadow_q};
      end else begin
        rdata_q  <= '0;
      end
    end
  end

  assign rdata    = rdata_q;
  assign shadow_o = shadow_q;
endmodule

// File: rtl/ftmr_top.sv
module ftmr_top #(
  parameter int                CNT_W   = ftmr_pkg::CNT_W,
  parameter int                DATA_W  = ftmr_pkg::DATA_W,
  parameter int                ADDR_W  = ftmr_pkg::ADDR_W,
  parameter logic [ADDR_W-1:0] LO_ADDR = ftmr_pkg::LO_ADDR,
  parameter logic [ADDR_W-1:0] HI_ADDR = ftmr_pkg::HI_ADDR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_fast,
  output logic              irq_slow
);
  localparam int NUM_IRQ = ftmr_pkg::NUM_IRQ;
  localparam int HI_W    = CNT_W - DATA_W;

  logic [CNT_W-1:0]   count;
  logic [HI_W-1:0]    shadow;
  logic [NUM_IRQ-1:0] irq_vec;

  ftmr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .count_o(count)
  );

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
    localparam int TAP = ftmr_pkg::irq_tap(g);
    ftmr_irq_tap #(.TAP(TAP)) u_tap (
      .clk(clk), .rst(rst), .tick(tick),
      .low_bits(count[TAP:0]), .irq_o(irq_vec[g])
    );
  end

  ftmr_rdport #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
  ) u_rdport (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr),
    .count(count), .rdata(rdata), .shadow_o(shadow)
  );

  assign irq_fast = irq_vec[0];
  assign irq_slow = irq_vec[1];
endmodule

// File: rtl/ftmr_checker.sv
module ftmr_checker #(
  parameter int CNT_W  = ftmr_pkg::CNT_W,
  parameter int DATA_W = ftmr_pkg::DATA_W,
  parameter int ADDR_W = ftmr_pkg::ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              irq_fast,
  input logic              irq_slow,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-DATA_W-1:0] shadow
);
  localparam logic [ADDR_W-1:0] LO = ftmr_pkg::LO_ADDR;
  localparam logic [ADDR_W-1:0] HI = ftmr_pkg::HI_ADDR;

  // R2: no tick, no movement
  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));
  // R2: one step per tick below the top value
  a_r2_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (tick && count != '1) |=> count == $past(count) + 1'b1);
  // R3: wrap to zero
  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (tick && count == '1) |=> count == '0);
  // R5: holding nibble changes only on a low-byte read
  a_r5_shadow_only_on_low_read: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && addr == LO) |=> $stable(shadow));
  // R6: high read clears the reserved bits
  a_r6_high_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == HI) |=> rdata[DATA_W-1:CNT_W-DATA_W] == '0);
  // R7: single-cycle pulse, caused by a tick
  a_r7_fast_one_cycle: assert property (@(posedge clk) disable iff (rst)
    irq_fast |=> !irq_fast);
  a_r7_fast_after_tick: assert property (@(posedge clk) disable iff (rst)
    irq_fast |-> $past(tick));
  // R8: slow pulse is single-cycle and coincides with a fast pulse
  a_r8_slow_one_cycle: assert property (@(posedge clk) disable iff (rst)
    irq_slow |=> !irq_slow);
  a_r8_slow_with_fast: assert property (@(posedge clk) disable iff (rst)
    irq_slow |-> irq_fast);
  // R9: unmapped read returns zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr != LO && addr != HI) |=> rdata == '0);
  // R10: read data holds while idle
  a_r10_rdata_holds: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind ftmr_top ftmr_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .irq_fast(irq_fast), .irq_slow(irq_slow),
  .count(count), .shadow(shadow)
);

// File: tb/tb_ftmr_top.sv
`timescale 1ns/1ps
module tb_ftmr_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] rdata;
  logic       irq_fast, irq_slow;

  int n_run = 0, n_fail = 0, n_fast = 0, n_slow = 0;
  logic [7:0] v;

  always #4 clk = ~clk;  // 125 MHz

  ftmr_top dut (.clk(clk), .rst(rst), .tick(tick), .rd_en(rd_en), .addr(addr),
                .rdata(rdata), .irq_fast(irq_fast), .irq_slow(irq_slow));

  always @(negedge clk) if (!rst) begin
    if (irq_fast) n_fast++;
    if (irq_slow) n_slow++;
  end

  // {ticks before low read, ticks between reads, expected low, expected high}
  localparam logic [47:0] VEC [8] = '{
    {16'd0,    16'd0,     8'h00, 8'h00},
    {16'd5,    16'd3,     8'h05, 8'h00},
    {16'd248,  16'd255,   8'h00, 8'h01},
    {16'd1,    16'd256,   8'h00, 8'h02},
    {16'd255,  16'd1,     8'hFF, 8'h03},
    {16'h06BC, 16'h0500,  8'hBC, 8'h0A},
    {16'h0043, 16'd1,     8'hFF, 8'h0F},
    {16'h0012, 16'd0,     8'h12, 8'h00}
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(posedge clk);
    end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; tick = 1'b0; rd_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int total;
    do_reset();
    // R1: reset state
    check("R1 rdata", rdata, 0);
    check("R1 irq_fast", irq_fast, 0);
    check("R1 irq_slow", irq_slow, 0);

    // table walk: R4 R5 R6 R3
    total = 0;
    n_fast = 0; n_slow = 0;
    foreach (VEC[i]) begin
      do_ticks(int'(VEC[i][47:32]));
      rd(8'h24, v);
      check("R4 low byte", v, int'(VEC[i][15:8]));
      do_ticks(int'(VEC[i][31:16]));
      rd(8'h25, v);
      check("R6 held high nibble", v, int'(VEC[i][7:0]));
      total += int'(VEC[i][47:32]) + int'(VEC[i][31:16]);
    end
    check("R7 fast pulse count", n_fast, total / 128);
    check("R8 slow pulse count", n_slow, total / 1024);

    // directed: R1 high read after reset
    do_reset();
    rd(8'h25, v);
    check("R1 high after reset", v, 0);

    // R7 exact timing
    do_ticks(127);
    check("R7 no pulse before 128", irq_fast, 0);
    @(negedge clk); tick = 1'b1;
    @(posedge clk);
    @(negedge clk); tick = 1'b0;
    check("R7 pulse after tick 128", irq_fast, 1);
    @(negedge clk);
    check("R7 pulse width", irq_fast, 0);
    rd(8'h24, v);
    check("R2 count 128", v, 8'h80);

    // R8 exact timing
    do_ticks(895);
    check("R8 no pulse before 1024", irq_slow, 0);
    @(negedge clk); tick = 1'b1;
    @(posedge clk);
    @(negedge clk); tick = 1'b0;
    check("R8 pulse after tick 1024", irq_slow, 1);
    check("R8 fast coincides", irq_fast, 1);
    @(negedge clk);
    check("R8 pulse width", irq_slow, 0);

    // R2 stall
    repeat (20) @(negedge clk);
    check("R2 no pulse while stalled", irq_fast, 0);
    rd(8'h24, v);
    check("R2 count held", v, 8'h00);

    // R4 read at the same edge as a tick returns pre-increment value
    @(negedge clk); tick = 1'b1; rd_en = 1'b1; addr = 8'h24;
    @(posedge clk);
    @(negedge clk); tick = 1'b0; rd_en = 1'b0;
    check("R4 same-edge low read", rdata, 8'h00);
    rd(8'h24, v);
    check("R4 next low read", v, 8'h01);

    // R9 unmapped read, shadow intact
    rd(8'h30, v);
    check("R9 unmapped zero", v, 0);
    rd(8'h25, v);
    check("R9 shadow intact", v, 8'h04);

    // R10 rdata holds while idle
    repeat (5) @(negedge clk);
    check("R10 rdata held", rdata, 8'h04);

    // R1 reset clears holding nibble
    do_reset();
    rd(8'h25, v);
    check("R1 shadow cleared", v, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule